// File: doc/BRIEF.md
# Audio Receiver Interrupt Controller

This block collects four event lines from a digital audio receiver and turns them into one interrupt pin. The four lines are a receiver-error flag, a channel-status buffer transfer flag (high while such a transfer runs), a user-data buffer transfer flag and a Q-subcode-ready flag. The error line only says that some fault happened. Its cause is read from a separate error register elsewhere. All four arrive as level signals on `evt_i` in that bit order (bit 0 to bit 3). Each line has its own 2-bit trigger selection that picks what latches a pending bit: a rising edge, a falling edge or a high level.

Pending bits stay set until software reads the status register. That read returns the latched bits and clears them in the same cycle. An enable bit for each source decides whether its pending bit can reach the pin. A 2-bit pin style field selects one of three drives: push-pull active-high, open-drain active-low or open-drain active-high. Open drain is modelled as a data value plus an output enable.

A small synchronous register port gives access to status, enables, trigger modes and pin style. Reads have one cycle of latency.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After synchronous reset, all pending, enable, trigger-mode and pin-style registers read as zero, and the pin is idle: `irq_o`=0 and `irq_oe_o`=1.
- R2: With trigger mode 00, a pending bit sets when its source goes from 0 to 1. A source that stays high or falls sets nothing.
- R3: With trigger mode 01, a pending bit sets when its source goes from 1 to 0. A rising edge alone sets nothing.
- R4: With trigger mode 10, a pending bit is set in every cycle its source is high, so it reappears right after a clearing read while the source stays high.
- R5: Trigger mode 11 is reserved and never sets the pending bit.
- R6: A read of address 0 returns the pending bits in bits [3:0] as they were before the read, and leaves them clear when no new event arrives in that cycle.
- R7: An event that arrives in the same cycle as a clearing read is absent from that read's data and remains pending afterwards.
- R8: A source whose enable bit (address 1, bit i for source i) is 0 still latches its pending bit but cannot activate the pin.
- R9: The pin turns active one cycle after any enabled pending bit is set. It turns idle one cycle after all enabled pending bits are clear.
- R10: Pin style (address 3, bits [1:0]) behaves as follows. With 00 the pin is push-pull: `irq_o` follows the active state and `irq_oe_o`=1. With 01 the pin is open-drain active-low: `irq_o`=0 and `irq_oe_o` is set while active. With 10 the pin is open-drain active-high: `irq_o`=1 and `irq_oe_o` is set while active. The reserved value 11 behaves like 00. A style change takes effect one cycle after the write.
- R11: Addresses 1, 2 and 3 read back the last written value. Address 2 holds source i's trigger mode at bits [2i+1:2i]. Writes to address 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC | Source level lines: error, channel-status transfer, user-data transfer, Q-subcode ready |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench uses the default build: four sources and an 8-bit data path. With these values all four trigger modes fit in one register write, so each table step can park three sources on the reserved mode and test one source in isolation. Each table entry sets a source value before the step, then applies two more values, and the edge and level outcomes follow from those three values. The directed part then walks each pin style while the pin is active and again while it is idle. It also lines an edge up with a clearing read in the same cycle.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_OFF   = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    PIN_HIGH_PP = 2'b00,
    PIN_LOW_OD  = 2'b01,
    PIN_HIGH_OD = 2'b10,
    PIN_RSVD    = 2'b11
  } pin_style_e;

  localparam logic [ADDR_W-1:0] REG_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] REG_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] REG_TRIG   = 2'd2;
  localparam logic [ADDR_W-1:0] REG_PIN    = 2'd3;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
  import audio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       src_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic prev_q;
  logic pend_q;
  logic hit;

  always_comb begin
    case (trig_mode_e'(mode_i))
      TRIG_RISE:  hit = src_i & ~prev_q;
      TRIG_FALL:  hit = ~src_i & prev_q;
      TRIG_LEVEL: hit = src_i;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      pend_q <= (pend_q & ~clr_i) | hit;
    end
  end

  assign pend_o = pend_q;

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TRIG_RISE && src_i && !prev_q) |=> pend_q);

  // R5
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == TRIG_OFF && !pend_q) |=> !pend_q);

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !hit) |=> !pend_q);

  // R7
  race_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && hit) |=> pend_q);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import audio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  localparam int MODE_W = 2 * NUM_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [1:0]        style_o,
  output logic              clr_o
);
  logic [NUM_SRC-1:0] enable_q;
  logic [MODE_W-1:0]  mode_q;
  logic [1:0]         style_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_val;
  logic               unused_wbits;

  assign unused_wbits = &{1'b0, wdata_i};

  always_comb begin
    rd_val = '0;
    case (addr_i)
      REG_STATUS: rd_val[NUM_SRC-1:0] = pend_i;
      REG_ENABLE: rd_val[NUM_SRC-1:0] = enable_q;
      REG_TRIG:   rd_val[MODE_W-1:0]  = mode_q;
      default:    rd_val[1:0]         = style_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      mode_q   <= '0;
      style_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr_en_i) begin
        case (addr_i)
          REG_ENABLE: enable_q <= wdata_i[NUM_SRC-1:0];
          REG_TRIG:   mode_q   <= wdata_i[MODE_W-1:0];
          REG_PIN:    style_q  <= wdata_i[1:0];
          default:    ;
        endcase
      end
      if (rd_en_i) rdata_q <= rd_val;
    end
  end

  assign clr_o    = rd_en_i && (addr_i == REG_STATUS);
  assign rdata_o  = rdata_q;
  assign enable_o = enable_q;
  assign mode_o   = mode_q;
  assign style_o  = style_q;

  // R11
  enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && addr_i == REG_ENABLE) |=> $stable(enable_q));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import audio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [1:0]         style_i,
  output logic               pin_o,
  output logic               oe_o
);
  logic active;
  logic pin_d, oe_d;
  logic pin_q, oe_q;

  assign active = |(pend_i & enable_i);

  always_comb begin
    case (pin_style_e'(style_i))
      PIN_LOW_OD: begin pin_d = 1'b0; oe_d = active; end
      PIN_HIGH_OD: begin pin_d = 1'b1; oe_d = active; end
      default: begin pin_d = active; oe_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;

  // R10
  push_pull_drives_chk: assert property (@(posedge clk) disable iff (rst)
    (style_i == PIN_HIGH_PP) |=> oe_q);
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [1:0]         addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               irq_oe_o
);
  localparam int MODE_W = 2 * NUM_SRC;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] enable;
  logic [MODE_W-1:0]  mode;
  logic [1:0]         style;
  logic               clr;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .pend_i(pend),
    .rdata_o(rdata_o), .enable_o(enable), .mode_o(mode),
    .style_o(style), .clr_o(clr)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_edge_latch latch_i (
      .clk(clk), .rst(rst), .src_i(evt_i[g]),
      .mode_i(mode[2*g +: 2]), .clr_i(clr), .pend_o(pend[g])
    );
  end

  irq_pin_drive #(.NUM_SRC(NUM_SRC)) pin_i (
    .clk(clk), .rst(rst), .pend_i(pend), .enable_i(enable),
    .style_i(style), .pin_o(irq_o), .oe_o(irq_oe_o)
  );

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (style == PIN_HIGH_PP && (pend & enable) == '0) |=> !irq_o);

  // R9
  low_od_track_chk: assert property (@(posedge clk) disable iff (rst)
    (style == PIN_LOW_OD && $past(style) == PIN_LOW_OD) |->
      (!irq_o && irq_oe_o == $past(|(pend & enable))));
endmodule

// File: tb/audio_irq_ctrl_tb.sv
module audio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] evt = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, irq_oe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  audio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  // {mode[1:0], v0, v1, v2, expected pending}
  localparam logic [5:0] VEC [13] = '{
    6'b00_000_0, 6'b00_011_1, 6'b00_111_0, 6'b00_110_0,
    6'b01_110_1, 6'b01_000_0, 6'b01_001_0, 6'b01_101_1,
    6'b10_000_0, 6'b10_010_1, 6'b10_001_1,
    6'b11_011_0, 6'b11_110_0
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    string tag;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    chk("R1 irq", {irq, irq_oe}, 2'b01);
    rd(2'd0, d); chk("R1 status", d, 0);
    rd(2'd1, d); chk("R1 enable", d, 0);
    rd(2'd2, d); chk("R1 trig", d, 0);
    rd(2'd3, d); chk("R1 style", d, 0);

    // R11 readback and ignored status write
    wr(2'd1, 8'h0A); rd(2'd1, d); chk("R11 enable", d, 8'h0A);
    wr(2'd2, 8'h5A); rd(2'd2, d); chk("R11 trig", d, 8'h5A);
    wr(2'd3, 8'h02); rd(2'd3, d); chk("R11 style", d, 8'h02);
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R11 status write ignored", d, 0);
    wr(2'd3, 8'h00); wr(2'd1, 8'h00);

    // table: source 0 trigger modes (R2 R3 R4 R5)
    for (int i = 0; i < 13; i++) begin
      logic [5:0] v;
      v = VEC[i];
      evt[0] = v[3];
      wr(2'd2, 8'hFF);
      tick();
      rd(2'd0, d);
      wr(2'd2, {6'b111111, v[5:4]});
      evt[0] = v[2]; tick();
      evt[0] = v[1]; tick();
      rd(2'd0, d);
      case (v[5:4])
        2'b00: tag = "R2 rising";
        2'b01: tag = "R3 falling";
        2'b10: tag = "R4 level";
        default: tag = "R5 reserved";
      endcase
      chk(tag, d, {7'b0, v[0]});
    end
    evt = '0;
    wr(2'd2, 8'hFF); tick(); rd(2'd0, d);

    // R4 level re-pends after a read while high
    wr(2'd2, 8'hFE); evt[0] = 1'b1; tick();
    rd(2'd0, d); rd(2'd0, d); chk("R4 level repend", d, 8'h01);
    evt[0] = 1'b0; wr(2'd2, 8'hFF); rd(2'd0, d);

    // R7 event on the clearing read cycle
    wr(2'd2, 8'hF3);
    rd_en = 1'b1; addr = 2'd0; evt[1] = 1'b1;
    tick();
    rd_en = 1'b0; d = rdata;
    chk("R7 read data excludes new event", d, 0);
    rd(2'd0, d); chk("R7 event kept", d, 8'h02);
    // R6 second read clears
    rd(2'd0, d); chk("R6 cleared after read", d, 0);
    evt[1] = 1'b0;

    // R8 masked source latches but pin idle
    wr(2'd2, 8'hEF); evt[2] = 1'b1; tick(); tick();
    chk("R8 pin idle while masked", {irq, irq_oe}, 2'b01);
    rd(2'd0, d); chk("R8 status latched", d, 8'h04);

    // R9 enable -> pin active one cycle later
    wr(2'd1, 8'h04);
    chk("R9 not yet active", irq, 0);
    tick();
    chk("R9 active", {irq, irq_oe}, 2'b11);

    // R10 styles while active
    wr(2'd3, 8'h01); tick(); chk("R10 low od active", {irq, irq_oe}, 2'b01);
    wr(2'd3, 8'h02); tick(); chk("R10 high od active", {irq, irq_oe}, 2'b11);
    wr(2'd3, 8'h03); tick(); chk("R10 reserved active", {irq, irq_oe}, 2'b11);
    wr(2'd3, 8'h01);

    // R9 deassert after clear
    evt[2] = 1'b0; tick();
    rd(2'd0, d);
    chk("R9 still active before update", irq_oe, 1);
    tick();
    chk("R10 low od idle", {irq, irq_oe}, 2'b00);
    wr(2'd3, 8'h02); tick(); chk("R10 high od idle", {irq, irq_oe}, 2'b10);
    wr(2'd3, 8'h00); tick(); chk("R9 push-pull idle", {irq, irq_oe}, 2'b01);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule